// File: doc/BRIEF.md
# Address-Descriptor Request Router

This block sits at the entry of an eight-port on-chip interconnect and decides, for each incoming request, which port receives it. Software loads a small table of address descriptors through a register-write port. Memory-space requests and I/O-space requests each have their own descriptor table. Every descriptor holds a base, a mask, an enable bit and a target port number. A request whose address falls inside an enabled descriptor of its own space goes to that descriptor's port. A request that matches nothing goes to a fixed default port.

The target port may be an endpoint device. It may also be a further interconnect unit, which runs the same address through its own descriptors. Port 0 stands for the interconnect unit itself. The router accepts one request at a time through a valid/ready handshake. It registers the chosen port together with the request and holds both until the downstream side takes them.

Top module: `reqPortRouter`

## Requirements
- R1: After reset, outValid is 0 and every descriptor is disabled, so every request is routed to the default port 4.
- R2: reqReady is 1 whenever outValid is 0 or outReady is 1. A request is accepted in a cycle where reqValid and reqReady are both 1.
- R3: An accepted request appears on the outputs at the next clock edge with outValid set. outBe and outIsIo are copied unchanged, and a memory request's outAddr equals reqAddr.
- R4: While outValid is 1 and outReady is 0, outValid, outPort, outAddr, outBe and outIsIo stay unchanged.
- R5: An enabled descriptor hits when (address & mask) == (base & mask). A request that hits one descriptor is routed to that descriptor's port.
- R6: A request that hits no enabled descriptor of its space is routed to port 4.
- R7: When several descriptors of one space hit, the lowest-numbered one decides the port.
- R8: A request with reqIsIo=0 is matched only against memory descriptors. A request with reqIsIo=1 is matched only against I/O descriptors.
- R9: I/O requests use only address bits 19:0. The upper request bits are ignored for matching, and outAddr bits 31:20 are 0 for an I/O request.
- R10: A configuration write uses the following encoding. cfgSpace selects the table: 0 is memory, 1 is I/O. cfgField selects the field: 0 is base, 1 is mask, 2 is control, and 3 is ignored. In the control field, bit 0 is the enable and bits 3:1 are the port. The write takes effect for requests accepted after the write cycle. A request accepted in the same cycle as a write is routed with the old contents.
- R11: A disabled descriptor never hits, whatever its base and mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Descriptor write strobe |
| cfgSpace | input | 1 | Table select: 0 memory, 1 I/O |
| cfgIdx | input | 2 | Descriptor index |
| cfgField | input | 2 | Field: 0 base, 1 mask, 2 control, 3 none |
| cfgData | input | 32 | Write data |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router can take a request |
| reqAddr | input | 32 | Byte address |
| reqIsIo | input | 1 | 1 for I/O space, 0 for memory space |
| reqBe | input | 4 | Byte enables |
| outValid | output | 1 | Forwarded request present |
| outReady | input | 1 | Downstream accepts the forwarded request |
| outPort | output | 3 | Chosen destination port |
| outAddr | output | 32 | Forwarded address |
| outIsIo | output | 1 | Forwarded space flag |
| outBe | output | 4 | Forwarded byte enables |

## Verification
The bench aims at overlapping descriptors. A router that resolved overlaps in the wrong order would send those requests to the higher-numbered descriptor's port. It also sends I/O requests that match a memory descriptor, and memory requests that match an I/O descriptor. A design that shared the tables between the spaces would route these to a wrong port instead of port 4.

It sends I/O addresses with junk in the upper twelve bits. A design that compared the full address would miss, and one that forwarded the full address would show nonzero high bits. It rewrites a descriptor in the very cycle a matching request is accepted. Random backpressure then checks that a held output never moves while the downstream side stalls.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } cfgField_e;

  typedef struct packed {
    logic acceptReq;
    logic retireOut;
  } rtrStrobe_t;
endpackage

// File: rtl/rtrCtrl.sv
module rtrCtrl
  import rtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       outReady,
  output logic       reqReady,
  output logic       outValid,
  output rtrStrobe_t strobe
);
  logic validQ;

  assign outValid         = validQ;
  assign reqReady         = !validQ || outReady;
  assign strobe.acceptReq = reqValid && reqReady;
  assign strobe.retireOut = validQ && outReady;

  always_ff @(posedge clk) begin
    if (!rstN)                 validQ <= 1'b0;
    else if (strobe.acceptReq) validQ <= 1'b1;
    else if (strobe.retireOut) validQ <= 1'b0;
  end

  // R3
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> outValid);

  // R4
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R2
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !reqReady);
endmodule

// File: rtl/rtrDatapath.sv
module rtrDatapath
  import rtr_pkg::*;
#(
  parameter int MEM_AW       = 32,
  parameter int IO_AW        = 20,
  parameter int N_MEM        = 4,
  parameter int N_IO         = 4,
  parameter int IDX_W        = 2,
  parameter int PORT_W       = 3,
  parameter int BE_W         = 4,
  parameter int DEFAULT_PORT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtrStrobe_t        strobe,
  input  logic              outValid,
  input  logic              outReady,
  input  logic              cfgWrEn,
  input  logic              cfgSpace,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [MEM_AW-1:0] cfgData,
  input  logic [MEM_AW-1:0] reqAddr,
  input  logic              reqIsIo,
  input  logic [BE_W-1:0]   reqBe,
  output logic [PORT_W-1:0] outPort,
  output logic [MEM_AW-1:0] outAddr,
  output logic              outIsIo,
  output logic [BE_W-1:0]   outBe
);
  logic [MEM_AW-1:0] memBase [N_MEM];
  logic [MEM_AW-1:0] memMask [N_MEM];
  logic [PORT_W-1:0] memPort [N_MEM];
  logic [N_MEM-1:0]  memEn;
  logic [IO_AW-1:0]  ioBase  [N_IO];
  logic [IO_AW-1:0]  ioMask  [N_IO];
  logic [PORT_W-1:0] ioPort  [N_IO];
  logic [N_IO-1:0]   ioEn;

  logic [N_MEM-1:0]  memHit;
  logic [N_IO-1:0]   ioHit;
  logic [IO_AW-1:0]  ioAddr;
  logic [PORT_W-1:0] selPort;
  logic [MEM_AW-1:0] fwdAddr;
  logic              anyHit;

  assign ioAddr = reqAddr[IO_AW-1:0];

  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    assign memHit[g] = memEn[g] && ((reqAddr & memMask[g]) == (memBase[g] & memMask[g]));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        memEn[g]   <= 1'b0;
        memBase[g] <= '0;
        memMask[g] <= '0;
        memPort[g] <= '0;
      end else if (cfgWrEn && !cfgSpace && cfgIdx == IDX_W'(g)) begin
        case (cfgField)
          FLD_BASE: memBase[g] <= cfgData;
          FLD_MASK: memMask[g] <= cfgData;
          FLD_CTRL: begin
            memEn[g]   <= cfgData[0];
            memPort[g] <= cfgData[PORT_W:1];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_IO; g++) begin : g_io
    assign ioHit[g] = ioEn[g] && ((ioAddr & ioMask[g]) == (ioBase[g] & ioMask[g]));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ioEn[g]   <= 1'b0;
        ioBase[g] <= '0;
        ioMask[g] <= '0;
        ioPort[g] <= '0;
      end else if (cfgWrEn && cfgSpace && cfgIdx == IDX_W'(g)) begin
        case (cfgField)
          FLD_BASE: ioBase[g] <= cfgData[IO_AW-1:0];
          FLD_MASK: ioMask[g] <= cfgData[IO_AW-1:0];
          FLD_CTRL: begin
            ioEn[g]   <= cfgData[0];
            ioPort[g] <= cfgData[PORT_W:1];
          end
          default: ;
        endcase
      end
    end
  end

  // Scan from the top down so the lowest index is written last and wins.
  always_comb begin
    selPort = PORT_W'(DEFAULT_PORT);
    if (reqIsIo) begin
      for (int i = N_IO - 1; i >= 0; i--)
        if (ioHit[i]) selPort = ioPort[i];
    end else begin
      for (int i = N_MEM - 1; i >= 0; i--)
        if (memHit[i]) selPort = memPort[i];
    end
  end

  assign anyHit = reqIsIo ? |ioHit : |memHit;

  always_comb begin
    fwdAddr = '0;
    fwdAddr[IO_AW-1:0] = ioAddr;
    if (!reqIsIo) fwdAddr = reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPort <= '0;
      outAddr <= '0;
      outIsIo <= 1'b0;
      outBe   <= '0;
    end else if (strobe.acceptReq) begin
      outPort <= selPort;
      outAddr <= fwdAddr;
      outIsIo <= reqIsIo;
      outBe   <= reqBe;
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outPort) && $stable(outAddr)
                              && $stable(outIsIo) && $stable(outBe));

  // R6
  miss_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptReq && !anyHit |=> outPort == PORT_W'(DEFAULT_PORT));

  // R7
  low_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptReq && !reqIsIo && memHit[0] |=> outPort == $past(memPort[0]));

  // R9
  io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIsIo |-> (outAddr >> IO_AW) == '0);
endmodule

// File: rtl/reqPortRouter.sv
module reqPortRouter
  import rtr_pkg::*;
#(
  parameter int MEM_AW       = 32,
  parameter int IO_AW        = 20,
  parameter int N_MEM        = 4,
  parameter int N_IO         = 4,
  parameter int IDX_W        = 2,
  parameter int PORT_W       = 3,
  parameter int BE_W         = 4,
  parameter int DEFAULT_PORT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSpace,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [1:0]        cfgField,
  input  logic [MEM_AW-1:0] cfgData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [MEM_AW-1:0] reqAddr,
  input  logic              reqIsIo,
  input  logic [BE_W-1:0]   reqBe,
  output logic              outValid,
  input  logic              outReady,
  output logic [PORT_W-1:0] outPort,
  output logic [MEM_AW-1:0] outAddr,
  output logic              outIsIo,
  output logic [BE_W-1:0]   outBe
);
  rtrStrobe_t strobe;

  rtrCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .outReady (outReady),
    .reqReady (reqReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  rtrDatapath #(
    .MEM_AW(MEM_AW), .IO_AW(IO_AW), .N_MEM(N_MEM), .N_IO(N_IO),
    .IDX_W(IDX_W), .PORT_W(PORT_W), .BE_W(BE_W), .DEFAULT_PORT(DEFAULT_PORT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outValid (outValid),
    .outReady (outReady),
    .cfgWrEn  (cfgWrEn),
    .cfgSpace (cfgSpace),
    .cfgIdx   (cfgIdx),
    .cfgField (cfgField),
    .cfgData  (cfgData),
    .reqAddr  (reqAddr),
    .reqIsIo  (reqIsIo),
    .reqBe    (reqBe),
    .outPort  (outPort),
    .outAddr  (outAddr),
    .outIsIo  (outIsIo),
    .outBe    (outBe)
  );
endmodule

// File: tb/tb_reqPortRouter.sv
`timescale 1ns/1ps
module tb_reqPortRouter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSpace = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [1:0]  cfgField = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqIsIo = 1'b0;
  logic [3:0]  reqBe = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [2:0]  outPort;
  logic [31:0] outAddr;
  logic        outIsIo;
  logic [3:0]  outBe;

  reqPortRouter dut (.*);

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int rdyMode = 1;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic [31:0] mBase [2][4];
  logic [31:0] mMask [2][4];
  logic [2:0]  mPortT [2][4];
  bit          mEn [2][4];
  bit          mValid;
  int          mPort;
  logic [31:0] mAddr;
  bit          mIo;
  logic [3:0]  mBe;
  string       mWhy;

  always @(negedge clk) begin
    case (rdyMode)
      0: outReady <= 1'b0;
      1: outReady <= 1'b1;
      default: outReady <= ($urandom % 3) != 0;
    endcase
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0;
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 4; i++) begin
          mEn[s][i] = 0; mBase[s][i] = 0; mMask[s][i] = 0; mPortT[s][i] = 0;
        end
    end else begin
      bit canTake;
      canTake = !mValid || outReady;
      if (mValid && outReady) mValid = 0;
      if (reqValid && canTake) begin
        int s, hits, sleepers;
        logic [31:0] a;
        s = reqIsIo ? 1 : 0;
        a = reqIsIo ? (reqAddr & 32'h000F_FFFF) : reqAddr;
        mPort = 4; hits = 0; sleepers = 0;
        for (int i = 0; i < 4; i++) begin
          if ((a & mMask[s][i]) == (mBase[s][i] & mMask[s][i])) begin
            if (mEn[s][i]) begin
              if (hits == 0) mPort = mPortT[s][i];
              hits++;
            end else sleepers++;
          end
        end
        if (cfgWrEn)                              mWhy = "R10";
        else if (reqIsIo && reqAddr[31:20] != 0) mWhy = "R9";
        else if (hits > 1)                        mWhy = "R7";
        else if (reqIsIo)                         mWhy = "R8";
        else if (hits == 1)                       mWhy = "R5";
        else if (sleepers > 0)                    mWhy = "R11";
        else                                      mWhy = "R6";
        mValid = 1; mAddr = a; mIo = reqIsIo; mBe = reqBe;
      end
      if (cfgWrEn) begin
        int s, i;
        s = cfgSpace; i = cfgIdx;
        case (cfgField)
          2'd0: mBase[s][i] = s ? (cfgData & 32'h000F_FFFF) : cfgData;
          2'd1: mMask[s][i] = s ? (cfgData & 32'h000F_FFFF) : cfgData;
          2'd2: begin mEn[s][i] = cfgData[0]; mPortT[s][i] = cfgData[3:1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R2 reqReady", 64'(reqReady), 64'(!mValid || outReady));
      chk("R3 outValid", 64'(outValid), 64'(mValid));
      if (mValid) begin
        chk({mWhy, " outPort"}, 64'(outPort), 64'(mPort));
        chk("R3 outAddr", 64'(outAddr), 64'(mAddr));
        chk("R3 outIsIo", 64'(outIsIo), 64'(mIo));
        chk("R3 outBe", 64'(outBe), 64'(mBe));
      end
    end
  end

  task automatic cfgWrite(input bit sp, input int idx, input int fld, input logic [31:0] d);
    cfgWrEn = 1; cfgSpace = sp; cfgIdx = 2'(idx); cfgField = 2'(fld); cfgData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic sendReq(input logic [31:0] a, input bit io, input logic [3:0] be);
    bit acc;
    reqValid = 1; reqAddr = a; reqIsIo = io; reqBe = be;
    forever begin
      #1 acc = reqReady;
      @(negedge clk);
      if (acc) break;
    end
    reqValid = 0;
  endtask

  task automatic setDesc(input bit sp, input int idx, input logic [31:0] b,
                         input logic [31:0] m, input int port, input bit en);
    cfgWrite(sp, idx, 0, b);
    cfgWrite(sp, idx, 1, m);
    cfgWrite(sp, idx, 2, {28'd0, 3'(port), en});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 outValid after reset", 64'(outValid), 64'd0);
    chk("R1 reqReady after reset", 64'(reqReady), 64'd1);
    // R1 / R6: empty tables route to port 4
    sendReq(32'h1234_5678, 0, 4'hF);
    sendReq(32'h0000_0400, 1, 4'h1);
    // R5 / R7: overlapping memory descriptors
    setDesc(0, 0, 32'h1000_0000, 32'hF000_0000, 2, 1);
    setDesc(0, 1, 32'h1200_0000, 32'hFF00_0000, 5, 1);
    sendReq(32'h1234_5678, 0, 4'h3);
    sendReq(32'h1FFF_0000, 0, 4'hC);
    sendReq(32'h2000_0000, 0, 4'h1);
    // R11: disable descriptor 0, descriptor 1 takes over
    cfgWrite(0, 0, 2, 32'h0000_0004);
    sendReq(32'h1234_5678, 0, 4'h3);
    sendReq(32'h1FFF_0000, 0, 4'h3);
    // R10: field 3 writes nothing
    cfgWrite(0, 1, 3, 32'hFFFF_FFFF);
    sendReq(32'h1200_0010, 0, 4'h2);
    // R8 / R9: I/O descriptor and space separation
    setDesc(1, 0, 32'h0000_0400, 32'h000F_FF00, 3, 1);
    sendReq(32'h0000_0420, 1, 4'h1);
    sendReq(32'h0000_0420, 0, 4'h1);
    sendReq(32'hABC0_0420, 1, 4'h3);
    sendReq(32'h1200_0000, 1, 4'hF);
    // R10: write in the same cycle as the accept uses the old table
    setDesc(0, 2, 32'h8000_0000, 32'h8000_0000, 6, 0);
    @(negedge clk);
    cfgWrEn = 1; cfgSpace = 0; cfgIdx = 2; cfgField = 2; cfgData = 32'h0000_000D;
    sendReq(32'h8000_0000, 0, 4'h5);
    cfgWrEn = 0;
    sendReq(32'h8000_0000, 0, 4'h5);
    // R4: stall the output, then release
    rdyMode = 0;
    sendReqNoWait(32'h1200_0000);
    repeat (6) @(negedge clk);
    rdyMode = 1;
    repeat (3) @(negedge clk);
    // random traffic with backpressure and rewrites
    rdyMode = 2;
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 5 == 0)
        cfgWrite($urandom % 2, $urandom % 4, $urandom % 4,
                 ($urandom % 2) ? 32'($urandom) & 32'hF0F0_000F : 32'($urandom));
      sendReq(($urandom % 2) ? 32'($urandom) : 32'($urandom) & 32'hF000_0F00,
              $urandom % 2, 4'($urandom));
    end
    rdyMode = 1;
    repeat (4) @(negedge clk);
    finish();
  end

  task automatic sendReqNoWait(input logic [31:0] a);
    reqValid = 1; reqAddr = a; reqIsIo = 0; reqBe = 4'h9;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic finish();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish();
    end
  end
endmodule